// File: doc/BRIEF.md
# Programmable CRC Syndrome Shift Register

This block computes a cyclic-redundancy syndrome one input bit at a time. Software first loads a set of configuration words: feedback taps, feed-forward (pre-multiplier) taps, a one-hot source mask, a zero-detect bit selection and an optional syndrome preset. It then issues single-shift commands. Each command carries one serial data bit. The block shifts that bit into a feedback shift register and then returns to idle by itself.

A two-bit mode word chooses how wide the register is. It can be one 24-bit section, or two 24-bit sections joined into a 48-bit register. In the joined form the upper section feeds the lower one. The bit chosen by the one-hot mask drives the feedback line, and its position sets the generator degree. An error flag reports a mask that is not one-hot. A zero flag reports when every selected register bit is clear.

Top module: `crc_syndrome_engine`

## Requirements
- R1: Configuration is written through `cfg_we`/`cfg_addr`/`cfg_wdata` using this address map: 0 = mode (bits 1:0), 1 = feedback taps (48 bits), 2 = feed-forward taps (48 bits), 3 = source mask (bits 23:0), 4 = zero-detect selection (48 bits), 5 = command (bit 0 start, bit 1 serial data bit, bit 2 zero-detect enable), 6 = syndrome preset (48 bits). A preset write appears on `syndrome` after the write edge.
- R2: While reset is held, the syndrome, every configuration word, `busy`, `zero_flag` and `mask_err` are all zero.
- R3: In mode 2'b10 only bits 23:0 shift. Each shift moves bit i+1 into bit i, bit 23 receives no upper bit, and bits 47:24 hold their value.
- R4: In mode 2'b11 all 48 bits shift as one register, so bit 24 (the lowest bit of the upper section) moves into bit 23.
- R5: The feedback line is the bit of syndrome[23:0] selected by the one-hot mask, taken before the shift. It is XORed into every bit whose feedback-tap bit is 1.
- R6: The command's serial data bit is XORed into every bit whose feed-forward-tap bit is 1.
- R7: If the mask is zero or has more than one bit set, the feedback line is 0. `mask_err` then reads 1, starting one cycle after the mask register takes that value.
- R8: A command with start = 1 raises `busy` on the next edge. The shift lands on the edge after that, and `busy` falls on that same edge. So a step takes two clocks and its start clears by itself.
- R9: Any configuration or command write made while `busy` is 1 is ignored.
- R10: In modes 2'b00 and 2'b01 a start command is ignored: no shift occurs and `busy` stays 0.
- R11: `zero_flag` is 1 when four things hold: zero detect is enabled, the mode is 2'b10 or 2'b11, at least one active bit is selected, and every selected active bit is 0. Active bits are bits 23:0 in mode 2'b10 and all 48 bits in mode 2'b11. The flag follows the register state with a lag of one cycle.
- R12: When no active bit is selected, `zero_flag` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration/command write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 48 | Configuration/command write data |
| busy | output | 1 | High during the cycle between a start command and its shift |
| syndrome | output | 48 | Shift register contents (bits 23:0 form the lower section) |
| zero_flag | output | 1 | Selected bits all zero |
| mask_err | output | 1 | Source mask is not one-hot |

## Verification
Each timing rule gets its own check point:
- A preset write is visible right after its write edge.
- A shift is due two edges after the start command is written, with `busy` high only at the sample taken between those two edges.
- `zero_flag` and `mask_err` are due one edge after the register values they depend on.

Every task drives inputs on the falling edge and samples on a later falling edge, counting those edges exactly. Writes are also placed inside the busy cycle, so that any leak into a later shift would show up in its result.

// File: rtl/crc_syn_pkg.sv
package crc_syn_pkg;
  typedef enum logic [2:0] {
    A_MODE = 3'd0,
    A_FBT  = 3'd1,
    A_FFT  = 3'd2,
    A_MASK = 3'd3,
    A_BSEL = 3'd4,
    A_CMD  = 3'd5,
    A_SYN  = 3'd6
  } cfg_addr_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ARM  = 1'b1
  } step_st_e;

  localparam int CMD_START = 0;
  localparam int CMD_DIN   = 1;
  localparam int CMD_ZDEN  = 2;
endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_syn_pkg::*;
#(
  parameter int SEC_W = 24,
  parameter int TOT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [TOT_W-1:0] wdata,
  output logic [1:0]       mode,
  output logic [TOT_W-1:0] fbt,
  output logic [TOT_W-1:0] fft,
  output logic [SEC_W-1:0] mask,
  output logic [TOT_W-1:0] bsel,
  output logic             zd_en,
  output logic             din,
  output logic             go,
  output logic             load_en,
  output logic [TOT_W-1:0] load_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= '0;
      fbt   <= '0;
      fft   <= '0;
      mask  <= '0;
      bsel  <= '0;
      zd_en <= 1'b0;
      din   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_MODE: mode <= wdata[1:0];
        A_FBT:  fbt  <= wdata;
        A_FFT:  fft  <= wdata;
        A_MASK: mask <= wdata[SEC_W-1:0];
        A_BSEL: bsel <= wdata;
        A_CMD: begin
          zd_en <= wdata[CMD_ZDEN];
          din   <= wdata[CMD_DIN];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    go       = wr_en && (addr == A_CMD) && wdata[CMD_START] && mode[1];
    load_en  = wr_en && (addr == A_SYN);
    load_val = wdata;
  end
endmodule

// File: rtl/crc_shift_core.sv
module crc_shift_core #(
  parameter int SEC_W = 24,
  parameter int TOT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chain,
  input  logic             shift_en,
  input  logic             load_en,
  input  logic [TOT_W-1:0] load_val,
  input  logic [TOT_W-1:0] fbt,
  input  logic [TOT_W-1:0] fft,
  input  logic [SEC_W-1:0] mask,
  input  logic             din,
  output logic [TOT_W-1:0] syn,
  output logic             mask_err
);
  logic             mask_ok;
  logic             fb;
  logic [TOT_W-1:0] moved;
  logic [TOT_W-1:0] nxt;

  always_comb begin
    mask_ok = (mask != '0) && ((mask & (mask - 1'b1)) == '0);
    fb      = mask_ok && (|(syn[SEC_W-1:0] & mask));
    moved   = {1'b0, syn[TOT_W-1:1]};
    if (!chain) begin
      moved[SEC_W-1] = 1'b0;
    end
    nxt = moved ^ (fbt & {TOT_W{fb}}) ^ (fft & {TOT_W{din}});
    if (!chain) begin
      nxt[TOT_W-1:SEC_W] = syn[TOT_W-1:SEC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syn      <= '0;
      mask_err <= 1'b0;
    end else begin
      mask_err <= !mask_ok;
      if (load_en) begin
        syn <= load_val;
      end else if (shift_en) begin
        syn <= nxt;
      end
    end
  end
endmodule

// File: rtl/crc_zero_detect.sv
module crc_zero_detect #(
  parameter int SEC_W = 24,
  parameter int TOT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             chain,
  input  logic [TOT_W-1:0] bsel,
  input  logic [TOT_W-1:0] syn,
  output logic             zero_flag
);
  localparam int NSEC = TOT_W / SEC_W;

  logic [NSEC-1:0] sec_sel;
  logic [NSEC-1:0] sec_hit;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic active;
    assign active     = (s == 0) || chain;
    assign sec_sel[s] = active && (|bsel[s*SEC_W +: SEC_W]);
    assign sec_hit[s] = active && (|(bsel[s*SEC_W +: SEC_W] & syn[s*SEC_W +: SEC_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_flag <= 1'b0;
    end else begin
      zero_flag <= enable && (|sec_sel) && !(|sec_hit);
    end
  end
endmodule

// File: rtl/crc_syndrome_engine.sv
module crc_syndrome_engine
  import crc_syn_pkg::*;
#(
  parameter int SEC_W = 24,
  parameter int TOT_W = 2 * SEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [TOT_W-1:0] cfg_wdata,
  output logic             busy,
  output logic [TOT_W-1:0] syndrome,
  output logic             zero_flag,
  output logic             mask_err
);
  step_st_e         st;
  logic             wr_ok;
  logic [1:0]       mode_q;
  logic [TOT_W-1:0] fbt_q;
  logic [TOT_W-1:0] fft_q;
  logic [SEC_W-1:0] mask_q;
  logic [TOT_W-1:0] bsel_q;
  logic             zd_en_q;
  logic             din_q;
  logic             go;
  logic             load_en;
  logic [TOT_W-1:0] load_val;

  assign wr_ok = cfg_we && (st == ST_IDLE);

  crc_cfg_regs #(.SEC_W(SEC_W), .TOT_W(TOT_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .mode    (mode_q),
    .fbt     (fbt_q),
    .fft     (fft_q),
    .mask    (mask_q),
    .bsel    (bsel_q),
    .zd_en   (zd_en_q),
    .din     (din_q),
    .go      (go),
    .load_en (load_en),
    .load_val(load_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (go) st <= ST_ARM;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st == ST_ARM);

  crc_shift_core #(.SEC_W(SEC_W), .TOT_W(TOT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .chain   (mode_q[0]),
    .shift_en(st == ST_ARM),
    .load_en (load_en),
    .load_val(load_val),
    .fbt     (fbt_q),
    .fft     (fft_q),
    .mask    (mask_q),
    .din     (din_q),
    .syn     (syndrome),
    .mask_err(mask_err)
  );

  crc_zero_detect #(.SEC_W(SEC_W), .TOT_W(TOT_W)) u_zd (
    .clk      (clk),
    .rst      (rst),
    .enable   (zd_en_q && mode_q[1]),
    .chain    (mode_q[0]),
    .bsel     (bsel_q),
    .syn      (syndrome),
    .zero_flag(zero_flag)
  );
endmodule

// File: rtl/crc_syndrome_checker.sv
module crc_syndrome_checker #(
  parameter int SEC_W = 24,
  parameter int TOT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic             busy,
  input logic [TOT_W-1:0] syndrome,
  input logic             zero_flag,
  input logic             mask_err,
  input logic [1:0]       mode_q,
  input logic [SEC_W-1:0] mask_q,
  input logic [TOT_W-1:0] bsel_q
);
  // R8: a step keeps busy high for exactly one cycle
  a_r8_busy_single: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  // R9 / R8: outside a step only a preset write may change the syndrome
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cfg_we && cfg_addr == 3'd6)) |=> $stable(syndrome));

  // R10: no step starts while parity coding is off
  a_r10_no_step_disabled: assert property (@(posedge clk) disable iff (rst)
    (!busy && !mode_q[1]) |=> !busy);

  // R3: in single-section mode the upper section never moves on a shift
  a_r3_upper_held: assert property (@(posedge clk) disable iff (rst)
    (busy && !mode_q[0]) |=> $stable(syndrome[TOT_W-1:SEC_W]));

  // R7: the error flag only follows a mask that is not one-hot
  a_r7_err_bad_mask: assert property (@(posedge clk) disable iff (rst)
    mask_err |-> !$onehot($past(mask_q)));

  // R12: zero detect needs at least one selected bit
  a_r12_zd_needs_sel: assert property (@(posedge clk) disable iff (rst)
    zero_flag |-> ($past(bsel_q) != '0));
endmodule

bind crc_syndrome_engine crc_syndrome_checker #(.SEC_W(SEC_W), .TOT_W(TOT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .busy     (busy),
  .syndrome (syndrome),
  .zero_flag(zero_flag),
  .mask_err (mask_err),
  .mode_q   (mode_q),
  .mask_q   (mask_q),
  .bsel_q   (bsel_q)
);

// File: tb/tb_crc_syndrome_engine.sv
module tb_crc_syndrome_engine;
  localparam int SW = 24;
  localparam int TW = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [TW-1:0] cfg_wdata = '0;
  logic          busy;
  logic [TW-1:0] syndrome;
  logic          zero_flag;
  logic          mask_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  crc_syndrome_engine #(.SEC_W(SW), .TOT_W(TW)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .syndrome(syndrome),
    .zero_flag(zero_flag), .mask_err(mask_err)
  );

  task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [TW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issue a start command; returns at the sample after the shift edge
  task automatic step(input bit d, input bit zden, input string req);
    wr(3'd5, {45'd0, zden, d, 1'b1});
    chk({req, " busy during step"}, {47'd0, busy}, 48'd1);
    @(negedge clk);
    chk({req, " busy cleared"}, {47'd0, busy}, 48'd0);
  endtask

  function automatic logic [TW-1:0] ref_next(logic [TW-1:0] s, bit ch, logic [TW-1:0] fb_t,
                                              logic [TW-1:0] ff_t, logic [SW-1:0] m, bit d);
    logic [TW-1:0] r;
    bit f;
    int top;
    f = 1'b0;
    if ($countones(m) == 1) f = |(s[SW-1:0] & m);
    top = ch ? TW - 1 : SW - 1;
    for (int i = 0; i < TW; i++) begin
      if (i > top) r[i] = s[i];
      else r[i] = ((i == top) ? 1'b0 : s[i+1]) ^ (fb_t[i] & f) ^ (ff_t[i] & d);
    end
    return r;
  endfunction

  task automatic t_reset;
    chk("R2 syndrome", syndrome, '0);
    chk("R2 busy", {47'd0, busy}, '0);
    chk("R2 zero_flag", {47'd0, zero_flag}, '0);
    chk("R2 mask_err", {47'd0, mask_err}, '0);
  endtask

  task automatic t_single_chain;
    wr(3'd0, 48'd2);
    wr(3'd3, 48'd1);
    wr(3'd1, '0);
    wr(3'd2, 48'h80_0000);
    wr(3'd6, 48'h1_000000);
    chk("R1 preset visible", syndrome, 48'h1_000000);
    step(1'b1, 1'b0, "R3");
    chk("R3 upper held, input at bit 23", syndrome, 48'h1_800000);
    wr(3'd0, 48'd3);
    wr(3'd2, '0);
    step(1'b0, 1'b0, "R4");
    chk("R4 bit 24 into bit 23", syndrome, 48'h0_C00000);
  endtask

  task automatic t_feedback;
    wr(3'd0, 48'd2);
    wr(3'd2, '0);
    wr(3'd3, 48'd1);
    wr(3'd1, 48'h80_0005);
    wr(3'd6, 48'd1);
    step(1'b0, 1'b0, "R5");
    chk("R5 feedback from bit 0", syndrome, 48'h80_0005);
    wr(3'd3, 48'h10);
    wr(3'd1, 48'h3);
    wr(3'd6, 48'h10);
    step(1'b0, 1'b0, "R5");
    chk("R5 feedback from bit 4", syndrome, 48'h0B);
    wr(3'd1, '0);
    wr(3'd2, 48'h41);
    wr(3'd6, '0);
    step(1'b1, 1'b0, "R6");
    chk("R6 feed-forward taps", syndrome, 48'h41);
  endtask

  task automatic t_bad_mask;
    wr(3'd0, 48'd2);
    wr(3'd2, '0);
    wr(3'd1, 48'hFF);
    wr(3'd3, 48'h3);
    @(negedge clk);
    chk("R7 mask_err on two bits", {47'd0, mask_err}, 48'd1);
    wr(3'd6, 48'd1);
    step(1'b0, 1'b0, "R7");
    chk("R7 feedback forced to 0", syndrome, '0);
    wr(3'd3, 48'd1);
    @(negedge clk);
    chk("R7 mask_err clears", {47'd0, mask_err}, '0);
  endtask

  task automatic t_busy_ignore;
    wr(3'd0, 48'd2);
    wr(3'd1, '0);
    wr(3'd3, 48'd1);
    wr(3'd2, 48'h80_0000);
    wr(3'd6, '0);
    wr(3'd5, 48'h3);
    chk("R8 busy after start", {47'd0, busy}, 48'd1);
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = '0;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 one shift done", syndrome, 48'h80_0000);
    chk("R8 start self-cleared", {47'd0, busy}, '0);
    @(negedge clk);
    chk("R8 no second shift", syndrome, 48'h80_0000);
    step(1'b1, 1'b0, "R9");
    chk("R9 busy-cycle write ignored", syndrome, 48'hC0_0000);
  endtask

  task automatic t_disabled;
    wr(3'd0, 48'd1);
    wr(3'd2, 48'hFFFF);
    wr(3'd6, 48'h55);
    wr(3'd5, 48'h3);
    chk("R10 no busy", {47'd0, busy}, '0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 no shift", syndrome, 48'h55);
  endtask

  task automatic t_zero;
    wr(3'd0, 48'd2);
    wr(3'd4, 48'h0F);
    wr(3'd5, 48'h4);
    wr(3'd6, 48'h10);
    @(negedge clk);
    chk("R11 zero on selected bits", {47'd0, zero_flag}, 48'd1);
    wr(3'd6, 48'h11);
    @(negedge clk);
    chk("R11 nonzero selected bit", {47'd0, zero_flag}, '0);
    wr(3'd5, 48'h0);
    wr(3'd6, 48'h10);
    @(negedge clk);
    chk("R11 disabled", {47'd0, zero_flag}, '0);
    wr(3'd5, 48'h4);
    wr(3'd4, 48'h1_000000);
    @(negedge clk);
    chk("R11 upper bits inactive in single mode", {47'd0, zero_flag}, '0);
    wr(3'd0, 48'd3);
    @(negedge clk);
    chk("R11 upper bits active when chained", {47'd0, zero_flag}, 48'd1);
    wr(3'd4, '0);
    @(negedge clk);
    chk("R12 no selection reads 0", {47'd0, zero_flag}, '0);
  endtask

  task automatic t_stream;
    logic [TW-1:0] exp_s;
    logic [7:0]    lf;
    logic [TW-1:0] fb_t;
    logic [TW-1:0] ff_t;
    fb_t = 48'h8000_0010_2021;
    ff_t = 48'h8000_0000_0001;
    lf = 8'hA5;
    wr(3'd0, 48'd3);
    wr(3'd1, fb_t);
    wr(3'd2, ff_t);
    wr(3'd3, 48'd1);
    wr(3'd6, 48'h1234_5678_9ABC);
    exp_s = 48'h1234_5678_9ABC;
    for (int i = 0; i < 20; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[0], 1'b0, "R5/R6 stream");
      exp_s = ref_next(exp_s, 1'b1, fb_t, ff_t, 24'd1, lf[0]);
      chk("R4 R5 R6 chained stream", syndrome, exp_s);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_single_chain();
    t_feedback();
    t_bad_mask();
    t_busy_ignore();
    t_disabled();
    t_zero();
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule